// File: doc/BRIEF.md
# Glitch-Free Clock Power-Down Controller

This block sits between a set of free-running generated clocks and the output pins. It stops those outputs cleanly when an asynchronous, active-high power-down request arrives, and restarts them when the request is removed. The block has two kinds of output. Single-ended clocks park low. Differential pairs park with the true side high and the complement side low. Each pair's output enables follow a per-pair park mode: either only the complement floats, or both sides float.

The request is first brought into the domain of a reference clock by a synchroniser. That clock is the complement of the CPU clock, and its rising edges do the sampling. The request counts only once it has been seen high on two rising edges in a row. The qualified hold is then carried into each output's own clock domain. There each output is gated only while its source sits at the level where it parks, so no pulse is ever cut short.

Once every output has parked, an oscillator-off indication asserts. On release this indication drops first. Each output then resumes at the same kind of edge on which it stopped.

Top module: `clk_pd_ctrl`

## Requirements
- R1: While reset is held, and afterwards with no request, every output follows its source clock. All output enables are 1. Oscillator-off and all-parked are both 0.
- R2: A request seen high on only one rising edge of the reference clock stops no output and never raises oscillator-off.
- R3: After a qualified request, each single-ended output goes low at a falling edge of its source. It stays low, with no edge, for as long as the request is held.
- R4: After a qualified request, each differential pair stops at a falling edge of its complement source. The true output is then held at 1 and the complement output at 0.
- R5: For a parked pair, park mode 0 gives a true enable of 1 and a complement enable of 0, while park mode 1 gives both enables 0. A running pair has both enables at 1.
- R6: Oscillator-off asserts only when every output is parked. While it is 1, no output changes level.
- R7: On release, oscillator-off falls before any output changes level. Every output then toggles again.
- R8: No high or low pulse on any single-ended output or differential true output is shorter than half of its source period.
- R9: All-parked is 1 while every output is stopped and 0 once the outputs run again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_i | input | 1 | Asynchronous active-high power-down request |
| ref_c_i | input | 1 | Complementary CPU reference clock; its rising edges sample the request |
| se_clk_i | input | N_SE | Free-running single-ended clock sources |
| dif_t_i | input | N_DIF | Differential true-side sources |
| dif_c_i | input | N_DIF | Differential complement-side sources |
| park_float_i | input | N_DIF | Per-pair park mode: 0 = true driven high, 1 = both sides floating |
| se_clk_o | output | N_SE | Gated single-ended clocks |
| dif_t_o | output | N_DIF | Gated true outputs |
| dif_c_o | output | N_DIF | Gated complement outputs |
| dif_t_oe | output | N_DIF | True-side output enable (0 = tri-state) |
| dif_c_oe | output | N_DIF | Complement-side output enable (0 = tri-state) |
| osc_off_o | output | 1 | Oscillator may be shut off |
| all_parked_o | output | 1 | Every output is in its parked state |

## Verification
The hardest case to reach from the ports is a request that lands on exactly one sampling edge of the reference clock. Such a request must be rejected. The bench raises it just after one rising edge and drops it just after the next. A second hard case is a request edge at an arbitrary phase against five unrelated output clocks. The bench offsets the request edges from the reference edge by random amounts, with a fixed seed. It also draws random park modes and random hold lengths, while pulse-width and edge-while-off monitors run for the whole test.

// File: rtl/clk_pd_pkg.sv
`timescale 1ns/1ps
package clk_pd_pkg;

  typedef enum logic {
    PARK_TRUE_HIGH  = 1'b0,
    PARK_BOTH_FLOAT = 1'b1
  } park_mode_e;

  // true-side enable of a pair given its stop state and park mode
  function automatic logic pair_oe_true(input logic stopped, input park_mode_e mode);
    return !(stopped && (mode == PARK_BOTH_FLOAT));
  endfunction

endpackage

// File: rtl/pd_sequencer.sv
`timescale 1ns/1ps
module pd_sequencer #(
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic req_i,
  input  logic parked_i,
  output logic hold_o,
  output logic osc_off_o,
  output logic parked_o
);

  localparam int unsigned LAST = SYNC_LEN - 1;

  logic [LAST:0] req_sync_q, req_sync_d;
  logic [LAST:0] park_sync_q, park_sync_d;
  logic          req_hist_q, req_hist_d;
  logic          qual_q, qual_d;
  logic          osc_q, osc_d;
  logic          hold_q, hold_d;

  // next state
  always_comb begin
    req_sync_d  = {req_sync_q[LAST-1:0], req_i};
    park_sync_d = {park_sync_q[LAST-1:0], parked_i};
    req_hist_d  = req_sync_q[LAST];
    qual_d      = req_sync_q[LAST] & req_hist_q;
    osc_d       = qual_q & park_sync_q[LAST];
    // once raised, hold stays until every output has parked, so a stop
    // sequence that has begun is always finished
    hold_d      = qual_q | osc_q | (hold_q & ~park_sync_q[LAST]);
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      req_sync_q  <= '0;
      park_sync_q <= '0;
      req_hist_q  <= 1'b0;
      qual_q      <= 1'b0;
      osc_q       <= 1'b0;
      hold_q      <= 1'b0;
    end else begin
      req_sync_q  <= req_sync_d;
      park_sync_q <= park_sync_d;
      req_hist_q  <= req_hist_d;
      qual_q      <= qual_d;
      osc_q       <= osc_d;
      hold_q      <= hold_d;
    end
  end

  assign hold_o    = hold_q;
  assign osc_off_o = osc_q;
  assign parked_o  = park_sync_q[LAST];

  // R2
  two_edge_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(qual_q) |-> ($past(req_sync_q[LAST], 1) && $past(req_sync_q[LAST], 2)));

  // R6
  osc_needs_park_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    osc_q |-> park_sync_q[LAST]);

  // R7
  osc_drops_first_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(osc_q) |-> hold_q);

endmodule

// File: rtl/pd_gate.sv
`timescale 1ns/1ps
module pd_gate #(
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic hold_i,
  output logic stop_o,
  output logic gclk_o
);

  localparam int unsigned LAST = SYNC_LEN - 1;

  logic [LAST:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[LAST-1:0], hold_i};
  end

  // falling edge: the source is low, so the gate may change without a runt
  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign stop_o = sync_q[LAST];
  assign gclk_o = clk_i & ~sync_q[LAST];

  // R3
  gate_low_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
    ($past(sync_q[LAST]) && sync_q[LAST]) |-> !gclk_o);

endmodule

// File: rtl/clk_pd_ctrl.sv
`timescale 1ns/1ps
module clk_pd_ctrl
  import clk_pd_pkg::*;
#(
  parameter int unsigned N_SE     = 3,
  parameter int unsigned N_DIF    = 2,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic             rst_n,
  input  logic             pd_req_i,
  input  logic             ref_c_i,
  input  logic [N_SE-1:0]  se_clk_i,
  input  logic [N_DIF-1:0] dif_t_i,
  input  logic [N_DIF-1:0] dif_c_i,
  input  logic [N_DIF-1:0] park_float_i,
  output logic [N_SE-1:0]  se_clk_o,
  output logic [N_DIF-1:0] dif_t_o,
  output logic [N_DIF-1:0] dif_c_o,
  output logic [N_DIF-1:0] dif_t_oe,
  output logic [N_DIF-1:0] dif_c_oe,
  output logic             osc_off_o,
  output logic             all_parked_o
);

  localparam int unsigned N_OUT = N_SE + N_DIF;

  logic [N_OUT-1:0] stop_all;
  logic             hold;

  pd_sequencer #(.SYNC_LEN(SYNC_LEN)) u_seq (
    .clk_i     (ref_c_i),
    .rst_n     (rst_n),
    .req_i     (pd_req_i),
    .parked_i  (&stop_all),
    .hold_o    (hold),
    .osc_off_o (osc_off_o),
    .parked_o  (all_parked_o)
  );

  for (genvar g = 0; g < N_SE; g++) begin : g_se
    pd_gate #(.SYNC_LEN(SYNC_LEN)) u_gate (
      .clk_i  (se_clk_i[g]),
      .rst_n  (rst_n),
      .hold_i (hold),
      .stop_o (stop_all[g]),
      .gclk_o (se_clk_o[g])
    );
  end

  for (genvar g = 0; g < N_DIF; g++) begin : g_dif
    // the complement source is gated; its falling edge is the true rising edge
    pd_gate #(.SYNC_LEN(SYNC_LEN)) u_gate (
      .clk_i  (dif_c_i[g]),
      .rst_n  (rst_n),
      .hold_i (hold),
      .stop_o (stop_all[N_SE+g]),
      .gclk_o (dif_c_o[g])
    );
    assign dif_t_o[g]  = dif_t_i[g] | stop_all[N_SE+g];
    assign dif_t_oe[g] = pair_oe_true(stop_all[N_SE+g], park_mode_e'(park_float_i[g]));
    assign dif_c_oe[g] = ~stop_all[N_SE+g];
  end

  // R6
  osc_off_levels_chk: assert property (@(posedge ref_c_i) disable iff (!rst_n)
    osc_off_o |-> ((se_clk_o == '0) && (&dif_t_o) && (dif_c_o == '0)));

endmodule

// File: tb/test_clk_pd_ctrl.sv
`timescale 1ns/1ps
module test_clk_pd_ctrl;

  localparam int N_SE  = 3;
  localparam int N_DIF = 2;

  logic             rst_n = 1'b0;
  logic             pd_req = 1'b0;
  logic             ref_c = 1'b0;
  logic [N_SE-1:0]  se_clk_i = '0;
  logic [N_DIF-1:0] dif_t_i = '0;
  logic [N_DIF-1:0] dif_c_i;
  logic [N_DIF-1:0] park_float = '0;
  logic [N_SE-1:0]  se_clk_o;
  logic [N_DIF-1:0] dif_t_o, dif_c_o, dif_t_oe, dif_c_oe;
  logic             osc_off, all_parked;

  int n_chk = 0;
  int n_bad = 0;
  int runt = 0;
  int osc_viol = 0;
  bit mon_en = 1'b0;
  bit osc_seen = 1'b0;
  bit done = 1'b0;
  int tog_se [N_SE];
  int tog_t  [N_DIF];
  int tog_c  [N_DIF];

  assign dif_c_i = ~dif_t_i;

  clk_pd_ctrl #(.N_SE(N_SE), .N_DIF(N_DIF)) i_clk_pd_ctrl (
    .rst_n        (rst_n),
    .pd_req_i     (pd_req),
    .ref_c_i      (ref_c),
    .se_clk_i     (se_clk_i),
    .dif_t_i      (dif_t_i),
    .dif_c_i      (dif_c_i),
    .park_float_i (park_float),
    .se_clk_o     (se_clk_o),
    .dif_t_o      (dif_t_o),
    .dif_c_o      (dif_c_o),
    .dif_t_oe     (dif_t_oe),
    .dif_c_oe     (dif_c_oe),
    .osc_off_o    (osc_off),
    .all_parked_o (all_parked)
  );

  function automatic real se_half(input int i);
    case (i)
      0: return 10.0;
      1: return 15.0;
      default: return 4.0;
    endcase
  endfunction

  function automatic real dif_half(input int i);
    return (i == 0) ? 6.0 : 8.0;
  endfunction

  // 100 MHz reference
  always #5 ref_c = ~ref_c;
  always #10 se_clk_i[0] = ~se_clk_i[0];
  always #15 se_clk_i[1] = ~se_clk_i[1];
  always #4  se_clk_i[2] = ~se_clk_i[2];
  always #6  dif_t_i[0] = ~dif_t_i[0];
  always #8  dif_t_i[1] = ~dif_t_i[1];

  // pulse-width and toggle monitors
  for (genvar g = 0; g < N_SE; g++) begin : g_mse
    realtime tr = 0.0, tf = 0.0;
    initial tog_se[g] = 0;
    always @(posedge se_clk_o[g]) if (mon_en) begin
      if ($realtime - tf < se_half(g) - 0.001) runt++;
      tr = $realtime; tog_se[g]++;
    end
    always @(negedge se_clk_o[g]) if (mon_en) begin
      if ($realtime - tr < se_half(g) - 0.001) runt++;
      tf = $realtime; tog_se[g]++;
    end
  end

  for (genvar g = 0; g < N_DIF; g++) begin : g_mdif
    realtime tr = 0.0, tf = 0.0;
    initial begin tog_t[g] = 0; tog_c[g] = 0; end
    always @(posedge dif_t_o[g]) if (mon_en) begin
      if ($realtime - tf < dif_half(g) - 0.001) runt++;
      tr = $realtime; tog_t[g]++;
    end
    always @(negedge dif_t_o[g]) if (mon_en) begin
      if ($realtime - tr < dif_half(g) - 0.001) runt++;
      tf = $realtime; tog_t[g]++;
    end
    always @(dif_c_o[g]) if (mon_en) tog_c[g]++;
  end

  always @(se_clk_o or dif_t_o or dif_c_o)
    if (mon_en && osc_off === 1'b1) osc_viol++;

  always @(posedge osc_off) osc_seen = 1'b1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [N_DIF-1:0] exp_t_oe(input logic [N_DIF-1:0] mode, input bit stopped);
    logic [N_DIF-1:0] r;
    for (int i = 0; i < N_DIF; i++) r[i] = !(stopped && mode[i]);
    return r;
  endfunction

  function automatic int sum_tog();
    int s = 0;
    for (int i = 0; i < N_SE; i++) s += tog_se[i];
    for (int i = 0; i < N_DIF; i++) s += tog_t[i] + tog_c[i];
    return s;
  endfunction

  task automatic sample_point();
    @(posedge ref_c);
    #3.3;
  endtask

  task automatic check_running(input string tag);
    int s0 [N_SE];
    int t0 [N_DIF];
    int c0 [N_DIF];
    bit moved;
    for (int i = 0; i < N_SE; i++) s0[i] = tog_se[i];
    for (int i = 0; i < N_DIF; i++) begin t0[i] = tog_t[i]; c0[i] = tog_c[i]; end
    #200;
    moved = 1'b1;
    for (int i = 0; i < N_SE; i++) if (tog_se[i] == s0[i]) moved = 1'b0;
    for (int i = 0; i < N_DIF; i++) if (tog_t[i] == t0[i] || tog_c[i] == c0[i]) moved = 1'b0;
    check(moved, tag, "every output toggles", moved, 1);
  endtask

  task automatic run_round(input logic [N_DIF-1:0] mode, input int hold_ns, input int off_ns);
    int snap;
    park_float = mode;
    @(posedge ref_c);
    #(off_ns);
    #0.3;
    pd_req = 1'b1;
    #500;
    sample_point();
    // R3
    check(se_clk_o == '0, "R3", "single-ended parked low", se_clk_o, 0);
    // R4
    check(dif_t_o == '1 && dif_c_o == '0, "R4", "pair parked true=1 comp=0",
          {dif_t_o, dif_c_o}, {{N_DIF{1'b1}}, {N_DIF{1'b0}}});
    // R5
    check(dif_t_oe == exp_t_oe(mode, 1'b1) && dif_c_oe == '0, "R5", "parked enables",
          {dif_t_oe, dif_c_oe}, {exp_t_oe(mode, 1'b1), {N_DIF{1'b0}}});
    // R6
    check(osc_off === 1'b1, "R6", "osc_off after parking", osc_off, 1);
    // R9
    check(all_parked === 1'b1, "R9", "all_parked while stopped", all_parked, 1);
    snap = sum_tog();
    #(hold_ns);
    // R3 no edge while held
    check(sum_tog() == snap, "R3", "no output edge during hold", sum_tog(), snap);
    #(off_ns);
    #0.7;
    pd_req = 1'b0;
    #500;
    sample_point();
    // R7
    check(osc_off === 1'b0, "R7", "osc_off dropped on release", osc_off, 0);
    // R9
    check(all_parked === 1'b0, "R9", "all_parked after release", all_parked, 0);
    // R5
    check(dif_t_oe == '1 && dif_c_oe == '1, "R5", "running enables",
          {dif_t_oe, dif_c_oe}, {2*N_DIF{1'b1}});
    check_running("R7");
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    #23;
    // R1 under reset
    check(se_clk_o == se_clk_i, "R1", "se follows source in reset", se_clk_o, se_clk_i);
    check(osc_off === 1'b0 && all_parked === 1'b0, "R1", "status low in reset",
          {osc_off, all_parked}, 0);
    @(posedge ref_c);
    #1;
    rst_n = 1'b1;
    #50;
    mon_en = 1'b1;
    sample_point();
    // R1
    check(se_clk_o == se_clk_i && dif_t_o == dif_t_i && dif_c_o == dif_c_i, "R1",
          "outputs follow sources", {se_clk_o, dif_t_o, dif_c_o}, {se_clk_i, dif_t_i, dif_c_i});
    check(dif_t_oe == '1 && dif_c_oe == '1, "R1", "enables high",
          {dif_t_oe, dif_c_oe}, {2*N_DIF{1'b1}});
    check(osc_off === 1'b0 && all_parked === 1'b0, "R1", "status low",
          {osc_off, all_parked}, 0);

    // R2 request seen on a single sampling edge
    osc_seen = 1'b0;
    @(posedge ref_c);
    #2;
    pd_req = 1'b1;
    @(posedge ref_c);
    #2;
    pd_req = 1'b0;
    fork
      check_running("R2");
    join
    check(osc_seen == 1'b0, "R2", "no osc_off from one-edge request", osc_seen, 0);
    check(all_parked === 1'b0, "R2", "not parked", all_parked, 0);

    // directed park modes
    run_round(2'b00, 100, 3);
    run_round(2'b11, 150, 7);
    run_round(2'b01, 60, 0);
    // random rounds
    for (int r = 0; r < 5; r++)
      run_round(2'($urandom_range(0, 3)), $urandom_range(50, 400), $urandom_range(0, 9));

    // R8
    check(runt == 0, "R8", "runt pulses seen", runt, 0);
    // R6 / R7
    check(osc_viol == 0, "R6", "output edges while osc_off high", osc_viol, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule